// File: doc/BRIEF.md
# Column Group Hit Cluster Encoder

This block compresses one row of binary pixel decisions for a group of 64 adjacent columns into a short list of cluster records. Every maximal run of fired pixels is cut into records that each cover at most four neighbouring columns. A record carries a 2-bit length code and the 6-bit column index of its first pixel inside the group. Only a fixed number of records per row is kept, six by default. If the row holds more, the encoder keeps the leftmost ones and raises a group overflow flag.

The row sequencer presents the 64-bit hit vector together with a one-cycle row strobe. One clock later the encoder presents its record list: a valid bit per slot, packed length and column fields, the overflow flag, and a one-cycle result strobe. The record list then stays unchanged until the next row is strobed. This lets a downstream row collector read the slots at its own pace between rows.

Top module: `hit_run_encoder`

## Requirements
- R1: `out_valid` is high in exactly the clock cycle that follows each cycle with `row_valid` high, and low otherwise; back-to-back rows produce back-to-back results.
- R2: Slot k occupies bits [2k+1:2k] of `state_len` and bits [6k+5:6k] of `state_col`; the length code equals run length minus one (00 = one pixel, 11 = four pixels) and the column field is the group-relative index (bit position in `hits`) of the record's first pixel.
- R3: When a row contains more than six records, the six with the lowest start columns are reported, all six valid bits are set and `overflow` is 1; with six or fewer records `overflow` is 0.
- R4: A run of more than four fired pixels is split into consecutive records; each record starts at the first pixel not covered by the previous record and covers up to four pixels.
- R5: Valid records fill slots from slot 0 upward without gaps, in strictly ascending column order, and no two records overlap.
- R6: A row with no fired pixel yields no valid slot and `overflow` = 0.
- R7: While `out_valid` is low, `state_vld`, `state_len`, `state_col` and `overflow` hold their last values, whatever `hits` does.
- R8: During and right after reset every output is zero.
- R9: Runs touching column 0 or column 63 are encoded like any other run, and a record never extends past column 63.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| row_valid | input | 1 | Strobe: `hits` holds a row to encode |
| hits | input | 64 | Fired pixel flags, bit i = column i of the group |
| out_valid | output | 1 | Result strobe, one cycle after `row_valid` |
| state_vld | output | 6 | Valid bit per record slot |
| state_len | output | 12 | Packed 2-bit length codes, slot k at [2k+1:2k] |
| state_col | output | 36 | Packed 6-bit start columns, slot k at [6k+5:6k] |
| overflow | output | 1 | More records existed than slots |

## Verification
The bench targets runs of exactly four, five and eight pixels. An encoder that miscounts the split point would either merge these into an illegal length or start the second record one column off. Rows with exactly six and exactly seven records check the overflow boundary; an off-by-one there shows up as a missing flag or as a dropped sixth record. Dense alternating patterns and a full row check that the leftmost records win and not arbitrary ones. Runs at columns 0 and 63 catch an encoder that wraps or reads beyond the group edge. Changing `hits` during idle cycles exposes any output that fails to hold.

// File: rtl/hre_pkg.sv
package hre_pkg;
    parameter int HRE_COLS       = 64;
    parameter int HRE_MAX_STATES = 6;
    parameter int HRE_RUN_MAX    = 4;
endpackage

// File: rtl/hre_start_mark.sv
// Marks the columns where a record begins and computes the length code a
// record starting at each column would carry.
module hre_start_mark #(
    parameter int COLS    = 64,
    parameter int RUN_MAX = 4,
    localparam int LEN_W  = $clog2(RUN_MAX)
) (
    input  logic [COLS-1:0]       hits,
    output logic [COLS-1:0]       start,
    output logic [COLS*LEN_W-1:0] len_flat
);
    logic [COLS+RUN_MAX-1:0] padded;

    assign padded = {{RUN_MAX{1'b0}}, hits};

    // Position inside the current run, modulo RUN_MAX: a record begins
    // whenever a fired pixel sits at position zero.
    always_comb begin
        logic [LEN_W-1:0] pos;
        pos   = '0;
        start = '0;
        for (int c = 0; c < COLS; c++) begin
            start[c] = hits[c] && (pos == '0);
            pos      = hits[c] ? pos + LEN_W'(1) : '0;
        end
    end

    // Number of further contiguous fired pixels after column c, capped.
    always_comb begin
        logic [LEN_W-1:0] n;
        logic             cont;
        len_flat = '0;
        for (int c = 0; c < COLS; c++) begin
            n    = '0;
            cont = 1'b1;
            for (int j = 1; j < RUN_MAX; j++) begin
                cont = cont & padded[c+j];
                if (cont) n = n + LEN_W'(1);
            end
            len_flat[c*LEN_W +: LEN_W] = n;
        end
    end
endmodule

// File: rtl/hre_first_one.sv
// Finds the lowest set bit of a vector and returns the vector without it.
module hre_first_one #(
    parameter int COLS   = 64,
    localparam int COL_W = $clog2(COLS)
) (
    input  logic [COLS-1:0]  vec_in,
    output logic             found,
    output logic [COL_W-1:0] idx,
    output logic [COLS-1:0]  vec_out
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = COLS - 1; i >= 0; i--) begin
            if (vec_in[i]) begin
                found = 1'b1;
                idx   = COL_W'(i);
            end
        end
    end

    assign vec_out = found ? (vec_in & ~(COLS'(1) << idx)) : vec_in;
endmodule

// File: rtl/hit_run_encoder.sv
module hit_run_encoder #(
    parameter int COLS       = hre_pkg::HRE_COLS,
    parameter int MAX_STATES = hre_pkg::HRE_MAX_STATES,
    parameter int RUN_MAX    = hre_pkg::HRE_RUN_MAX,
    localparam int COL_W     = $clog2(COLS),
    localparam int LEN_W     = $clog2(RUN_MAX)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        row_valid,
    input  logic [COLS-1:0]             hits,
    output logic                        out_valid,
    output logic [MAX_STATES-1:0]       state_vld,
    output logic [MAX_STATES*LEN_W-1:0] state_len,
    output logic [MAX_STATES*COL_W-1:0] state_col,
    output logic                        overflow
);
    typedef struct packed {
        logic                        out_valid;
        logic [MAX_STATES-1:0]       vld;
        logic [MAX_STATES*LEN_W-1:0] len;
        logic [MAX_STATES*COL_W-1:0] col;
        logic                        ovf;
    } enc_state_t;

    enc_state_t cur_q, nxt_d;

    logic [COLS-1:0]       start;
    logic [COLS*LEN_W-1:0] len_flat;
    logic                  sel_found [MAX_STATES];
    logic [COL_W-1:0]      sel_idx   [MAX_STATES];
    logic [COLS-1:0]       leftover;

    hre_start_mark #(.COLS(COLS), .RUN_MAX(RUN_MAX)) u_mark (
        .hits     (hits),
        .start    (start),
        .len_flat (len_flat)
    );

    // Chain of lowest-bit pickers: stage k takes the k-th record in
    // column order.
    for (genvar k = 0; k < MAX_STATES; k++) begin : g_stage
        logic [COLS-1:0] vin;
        logic [COLS-1:0] vout;
        if (k == 0) begin : g_head
            assign vin = start;
        end else begin : g_link
            assign vin = g_stage[k-1].vout;
        end
        hre_first_one #(.COLS(COLS)) u_pick (
            .vec_in  (vin),
            .found   (sel_found[k]),
            .idx     (sel_idx[k]),
            .vec_out (vout)
        );
    end

    assign leftover = g_stage[MAX_STATES-1].vout;

    always_comb begin
        nxt_d           = cur_q;
        nxt_d.out_valid = row_valid;
        if (row_valid) begin
            for (int k = 0; k < MAX_STATES; k++) begin
                nxt_d.vld[k] = sel_found[k];
                nxt_d.len[k*LEN_W +: LEN_W] = sel_found[k] ?
                    len_flat[int'(sel_idx[k])*LEN_W +: LEN_W] : '0;
                nxt_d.col[k*COL_W +: COL_W] = sel_found[k] ? sel_idx[k] : '0;
            end
            nxt_d.ovf = |leftover;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign out_valid = cur_q.out_valid;
    assign state_vld = cur_q.vld;
    assign state_len = cur_q.len;
    assign state_col = cur_q.col;
    assign overflow  = cur_q.ovf;
endmodule

// File: rtl/hre_checker.sv
module hre_checker #(
    parameter int COLS       = 64,
    parameter int MAX_STATES = 6,
    parameter int RUN_MAX    = 4,
    localparam int COL_W     = $clog2(COLS),
    localparam int LEN_W     = $clog2(RUN_MAX)
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        row_valid,
    input logic [COLS-1:0]             hits,
    input logic                        out_valid,
    input logic [MAX_STATES-1:0]       state_vld,
    input logic [MAX_STATES*LEN_W-1:0] state_len,
    input logic [MAX_STATES*COL_W-1:0] state_col,
    input logic                        overflow
);
    p_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
        row_valid |=> out_valid);
    p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !row_valid |=> !out_valid);
    p_ovf_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |-> (&state_vld));
    p_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (row_valid && hits == '0) |=> (state_vld == '0 && !overflow));
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> ($stable(state_vld) && $stable(state_len) &&
                        $stable(state_col) && $stable(overflow)));

    for (genvar k = 0; k < MAX_STATES; k++) begin : g_slot
        p_fit_r9: assert property (@(posedge clk) disable iff (!rst_n)
            state_vld[k] |-> (int'(state_col[k*COL_W +: COL_W]) +
                              int'(state_len[k*LEN_W +: LEN_W]) < COLS));
        if (k + 1 < MAX_STATES) begin : g_pair
            p_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
                state_vld[k+1] |-> (state_vld[k] &&
                    int'(state_col[(k+1)*COL_W +: COL_W]) >
                    int'(state_col[k*COL_W +: COL_W]) +
                    int'(state_len[k*LEN_W +: LEN_W])));
        end
    end
endmodule

bind hit_run_encoder hre_checker #(
    .COLS(COLS), .MAX_STATES(MAX_STATES), .RUN_MAX(RUN_MAX)
) u_chk (.*);

// File: tb/hit_run_encoder_test.sv
module hit_run_encoder_test;
    localparam int NC = 64;
    localparam int NS = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          row_valid = 1'b0;
    logic [NC-1:0] hits = '0;
    logic          out_valid;
    logic [NS-1:0] state_vld;
    logic [NS*2-1:0] state_len;
    logic [NS*6-1:0] state_col;
    logic          overflow;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int exp_n;
    int exp_col [32];
    int exp_len [32];

    always #5 clk = ~clk;

    hit_run_encoder uut (
        .clk(clk), .rst_n(rst_n), .row_valid(row_valid), .hits(hits),
        .out_valid(out_valid), .state_vld(state_vld), .state_len(state_len),
        .state_col(state_col), .overflow(overflow)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Reference: walk left to right, cut runs into pieces of at most four.
    task automatic ref_encode(input logic [NC-1:0] h);
        int c;
        c = 0;
        exp_n = 0;
        while (c < NC) begin
            if (h[c]) begin
                int l = 0;
                while (c + l < NC && l < 4 && h[c+l]) l++;
                if (exp_n < 32) begin
                    exp_col[exp_n] = c;
                    exp_len[exp_n] = l - 1;
                end
                exp_n++;
                c += l;
            end else begin
                c++;
            end
        end
    endtask

    task automatic check_outputs(input logic [NC-1:0] h, input string tag);
        ref_encode(h);
        chk(out_valid == 1'b1, "R1", {tag, " out_valid after row"}, out_valid, 1);
        for (int k = 0; k < NS; k++) begin
            bit ev = (k < exp_n);
            chk(state_vld[k] == ev, "R5", {tag, " slot valid"}, state_vld[k], ev);
            if (ev) begin
                chk(int'(state_col[k*6 +: 6]) == exp_col[k], "R2",
                    {tag, " start column"}, state_col[k*6 +: 6], exp_col[k]);
                chk(int'(state_len[k*2 +: 2]) == exp_len[k], "R2",
                    {tag, " length code"}, state_len[k*2 +: 2], exp_len[k]);
            end
        end
        chk(overflow == (exp_n > NS), "R3", {tag, " overflow"}, overflow, exp_n > NS);
    endtask

    task automatic run_row(input logic [NC-1:0] h, input string tag);
        logic [NS-1:0]   sv;
        logic [NS*2-1:0] sl;
        logic [NS*6-1:0] sc;
        logic            so;
        @(negedge clk);
        hits = h;
        row_valid = 1'b1;
        @(negedge clk);
        row_valid = 1'b0;
        hits = {$urandom, $urandom};
        check_outputs(h, tag);
        sv = state_vld; sl = state_len; sc = state_col; so = overflow;
        @(negedge clk);
        hits = {$urandom, $urandom};
        chk(out_valid == 1'b0, "R1", {tag, " out_valid drops"}, out_valid, 0);
        chk({state_vld, state_len, state_col, overflow} == {sv, sl, sc, so}, "R7",
            {tag, " outputs hold"}, {state_vld, overflow}, {sv, so});
    endtask

    function automatic logic [NC-1:0] rand_row(input int mode);
        logic [NC-1:0] a, b, c;
        a = {$urandom, $urandom};
        b = {$urandom, $urandom};
        c = {$urandom, $urandom};
        case (mode)
            0:       return a & b & c;
            1:       return a & b;
            2:       return a;
            default: return a | b;
        endcase
    endfunction

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R8: reset state
        chk({out_valid, state_vld, state_len, state_col, overflow} == '0, "R8",
            "outputs in reset", {state_vld, overflow}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({out_valid, state_vld, state_len, state_col, overflow} == '0, "R8",
            "outputs after reset", {state_vld, overflow}, 0);

        run_row('0, "R6 empty row");
        run_row(64'h1, "R9 column 0 single");
        run_row(64'h8000_0000_0000_0000, "R9 column 63 single");
        run_row(64'hF000_0000_0000_0000, "R9 run of four at top edge");
        run_row(64'h0000_0000_0000_000F, "R4 run of exactly four");
        run_row(64'h0000_0000_0000_01F0, "R4 run of five");
        run_row(64'hFC00_0000_0000_0000, "R4 run of six at top edge");
        run_row(64'h0000_0000_00FF_0000, "R4 run of eight");
        run_row(64'h0000_0000_0000_0555, "R3 exactly six records");
        run_row(64'h0000_0000_0000_1555, "R3 seven records");
        run_row(64'hAAAA_AAAA_AAAA_AAAA, "R3 alternating");
        run_row('1, "R3 R4 full row");

        // R1: back-to-back rows
        @(negedge clk);
        hits = 64'h0000_0000_0000_0007;
        row_valid = 1'b1;
        @(negedge clk);
        hits = 64'h0300_0000_0000_0000;
        check_outputs(64'h0000_0000_0000_0007, "R1 back-to-back first");
        @(negedge clk);
        row_valid = 1'b0;
        check_outputs(64'h0300_0000_0000_0000, "R1 back-to-back second");

        for (int i = 0; i < 400; i++) begin
            run_row(rand_row(i % 4), "R2 R5 random row");
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule